// File: doc/BRIEF.md
# SD/MMC Host Command Engine

This block drives the command line of an SD or MMC card. Software first loads a 32-bit argument, then writes a command word; that write launches the command on the next clock. The block serializes a 48-bit command frame with its CRC7 and then, depending on the command, waits for the card's reply, receives a 48-bit or 136-bit response, checks its CRC and stores the payload. Some commands leave the card busy after the reply (a stop-transmission command, for instance). For these the block holds off all new commands until the card releases the DAT0 line.

The state machine has five states. IDLE (ready) takes a launch to TX. TX shifts out 48 bits and then goes back to IDLE when no response is expected, or on to WAIT. WAIT watches for a start bit: it goes to RX when the bit is seen, or back to IDLE with the timeout flag when the latency window runs out. RX collects the response and then goes to IDLE, or to BUSY for busy-type commands. BUSY goes back to IDLE once DAT0 is seen high after a minimum hold time. One bit moves per clock.

The command word holds these fields: bits [5:0] carry the command index, bits [7:6] the response kind, bit [8] the open-drain select and bit [9] the latency select.

Top module: `sdcmd_engine`

## Requirements
- R1: A `cmd_we` pulse while `st_ready` is high launches a command. From the next cycle the line carries 48 bits, one per clock, MSB first: 0, 1, index[5:0], the argument latched by the last `arg_we` before the launch cycle, CRC7, and 1. An `arg_we` during transmission does not change the frame in flight.
- R2: The CRC7 uses polynomial x^7+x^3+1, starts at zero and covers the first 40 frame bits.
- R3: With bit [8] set, a 0 bit is driven low (`cmd_oe`=1, `cmd_out`=0) and a 1 bit is released (`cmd_oe`=0). With bit [8] clear, `cmd_oe`=1 and `cmd_out` equals the bit. Outside transmission `cmd_oe`=0.
- R4: The response kind is given by bits [7:6]: 0 means no response, 1 a 48-bit response, 2 a 136-bit response, 3 a 48-bit response followed by busy. For kind 0, `st_ready` is high in the cycle after the end bit.
- R5: A response start bit (0 on `cmd_in`) is accepted during the first N cycles after the end bit. N is 5 when bit [9] is 0 and 64 when it is 1. Otherwise `st_timeout` sets and the block returns to ready.
- R6: After a 48-bit response, `rsp_data[31:0]` holds the 32 bits that follow the 8-bit header and the upper bits read zero. After a 136-bit response, `rsp_data` holds the 128 bits that follow the header.
- R7: The response CRC7 covers bits 0..39 of a 48-bit response or bits 8..127 of a 136-bit response. It is compared with the 7 bits before the end bit, and a mismatch sets `st_crcerr`.
- R8: For kind 3, after the response end bit `st_notbusy` and `st_ready` are low. They stay low for at least 2 cycles and until `dat0_in` is sampled high.
- R9: A `cmd_we` while `st_ready` is low is ignored. The line and the activity in progress are unaffected, and `st_overrun` sets.
- R10: Reset leaves `st_ready` and `st_notbusy` high, all flags low, `cmd_oe` low and `rsp_data` zero. An accepted launch clears `st_timeout`, `st_crcerr` and `st_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command register write strobe (launch) |
| cmd_wdata | input | 10 | Command word: index, kind, open-drain, latency |
| cmd_in | input | 1 | Sampled level of the command line |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Output enable for the command line |
| dat0_in | input | 1 | DAT0 level, low while the card is busy |
| st_ready | output | 1 | Engine idle, a command may be launched |
| st_notbusy | output | 1 | Low while waiting for the card's busy release |
| st_timeout | output | 1 | No response start bit within the window |
| st_crcerr | output | 1 | Response CRC mismatch |
| st_overrun | output | 1 | A command write was refused |
| rsp_data | output | 128 | Stored response payload |

## Verification
The bench aims at the edges of the latency window. A start bit in the last accepted cycle must be taken, and one cycle later must time out. An off-by-one window would either miss a valid reply or hang in WAIT. It corrupts single payload bits in both response lengths and compares the stored payload. A CRC over the wrong span, or a payload taken at the wrong offset, shows up as a wrong flag or wrong data. It writes commands and arguments during transmission and during busy, and holds DAT0 low for zero to several cycles. A design that accepted those writes would corrupt the frame or drive the line. A design that left busy too early would report ready while the card was still busy.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY
    } sd_state_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_BUSY  = 2'd3
    } rsp_kind_e;

    // one serial step of CRC7 (x^7 + x^3 + 1)
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
`timescale 1ns/1ps
module sdcmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    import sdcmd_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc7_step(crc, din);
    end
endmodule

// File: rtl/sdcmd_timer.sv
`timescale 1ns/1ps
module sdcmd_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (~&cnt)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdcmd_engine.sv
`timescale 1ns/1ps
module sdcmd_engine #(
    parameter int LAT_SHORT = 5,
    parameter int LAT_LONG  = 64,
    parameter int BUSY_HOLD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arg_we,
    input  logic [31:0]  arg_wdata,
    input  logic         cmd_we,
    input  logic [9:0]   cmd_wdata,
    input  logic         cmd_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    input  logic         dat0_in,
    output logic         st_ready,
    output logic         st_notbusy,
    output logic         st_timeout,
    output logic         st_crcerr,
    output logic         st_overrun,
    output logic [127:0] rsp_data
);
    import sdcmd_pkg::*;

    localparam int CNT_W = $clog2(LAT_LONG + BUSY_HOLD + 1);
    localparam logic [CNT_W-1:0] WIN_S     = CNT_W'(LAT_SHORT - 1);
    localparam logic [CNT_W-1:0] WIN_L     = CNT_W'(LAT_LONG - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(BUSY_HOLD - 1);
    localparam logic [7:0] TX_PAYLOAD = 8'd40;
    localparam logic [7:0] TX_LAST    = 8'd47;
    localparam logic [7:0] HDR_BITS   = 8'd8;
    localparam logic [7:0] LONG_CRC_END = 8'd128;
    localparam logic [7:0] LONG_LAST  = 8'd135;

    sd_state_e state_q, state_d;
    rsp_kind_e kind_q;
    logic [31:0]  arg_q;
    logic [39:0]  txsh_q;
    logic         od_q, lat_q;
    logic [7:0]   pos_q;
    logic [126:0] sh_q;
    logic [CNT_W-1:0] wcnt;
    logic [6:0]   tx_crc, rx_crc;

    logic launch, tx_bit, rx_valid, is_long, rx_crc_en;
    logic [7:0] rx_pos, last_pos;
    logic [CNT_W-1:0] win_last;

    assign launch   = cmd_we && (state_q == S_IDLE);
    assign is_long  = (kind_q == RSP_LONG);
    assign last_pos = is_long ? LONG_LAST : TX_LAST;
    assign win_last = lat_q ? WIN_L : WIN_S;
    assign rx_valid = ((state_q == S_WAIT) && !cmd_in) || (state_q == S_RX);
    assign rx_pos   = (state_q == S_RX) ? pos_q : 8'd0;
    assign rx_crc_en = rx_valid && (is_long ? (rx_pos >= HDR_BITS && rx_pos < LONG_CRC_END)
                                            : (rx_pos < TX_PAYLOAD));

    always_comb begin
        if (pos_q < TX_PAYLOAD)   tx_bit = txsh_q[39];
        else if (pos_q < TX_LAST) tx_bit = tx_crc[3'(8'd46 - pos_q)];
        else                      tx_bit = 1'b1;
    end

    sdcmd_crc7 u_tx_crc (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .en((state_q == S_TX) && (pos_q < TX_PAYLOAD)),
        .din(txsh_q[39]), .crc(tx_crc)
    );

    sdcmd_crc7 u_rx_crc (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_TX),
        .en(rx_crc_en), .din(cmd_in), .crc(rx_crc)
    );

    sdcmd_timer #(.CW(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(wcnt)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_TX;
            S_TX:   if (pos_q == TX_LAST)
                        state_d = (kind_q == RSP_NONE) ? S_IDLE : S_WAIT;
            S_WAIT: if (!cmd_in)             state_d = S_RX;
                    else if (wcnt == win_last) state_d = S_IDLE;
            S_RX:   if (pos_q == last_pos)
                        state_d = (kind_q == RSP_BUSY) ? S_BUSY : S_IDLE;
            S_BUSY: if (wcnt >= HOLD_LAST && dat0_in) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0; txsh_q <= '0; od_q <= 1'b0; lat_q <= 1'b0;
            kind_q <= RSP_NONE; pos_q <= '0; sh_q <= '0; rsp_data <= '0;
            st_timeout <= 1'b0; st_crcerr <= 1'b0; st_overrun <= 1'b0;
        end else begin
            if (arg_we) arg_q <= arg_wdata;
            if (cmd_we && state_q != S_IDLE) st_overrun <= 1'b1;
            if (launch) begin
                txsh_q <= {1'b0, 1'b1, cmd_wdata[5:0], arg_q};
                kind_q <= rsp_kind_e'(cmd_wdata[7:6]);
                od_q   <= cmd_wdata[8];
                lat_q  <= cmd_wdata[9];
                pos_q  <= '0;
                sh_q   <= '0;
                st_timeout <= 1'b0;
                st_crcerr  <= 1'b0;
                st_overrun <= 1'b0;
            end
            if (state_q == S_TX) begin
                txsh_q <= {txsh_q[38:0], 1'b0};
                pos_q  <= pos_q + 8'd1;
            end
            if (state_q == S_WAIT) begin
                pos_q <= 8'd1;
                if (cmd_in && wcnt == win_last) st_timeout <= 1'b1;
            end
            if (state_q == S_RX) pos_q <= pos_q + 8'd1;
            if (rx_valid && rx_pos >= HDR_BITS) sh_q <= {sh_q[125:0], cmd_in};
            if (state_q == S_RX && pos_q == last_pos) begin
                rsp_data  <= is_long ? {sh_q, cmd_in} : {96'b0, sh_q[38:7]};
                st_crcerr <= (rx_crc != sh_q[6:0]);
            end
        end
    end

    // outputs
    always_comb begin
        st_ready   = (state_q == S_IDLE);
        st_notbusy = (state_q != S_BUSY);
        cmd_oe     = 1'b0;
        cmd_out    = 1'b1;
        if (state_q == S_TX) begin
            cmd_oe  = od_q ? !tx_bit : 1'b1;
            cmd_out = od_q ? 1'b0 : tx_bit;
        end
    end

    p_launch_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ready && cmd_we) |=> (cmd_oe && !cmd_out));
    p_line_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_TX) |-> !cmd_oe);
    p_none_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TX && pos_q == TX_LAST && kind_q == RSP_NONE) |=> st_ready);
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |-> (wcnt <= win_last));
    p_busy_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_notbusy |-> !st_ready);
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ready && cmd_we) |=> st_overrun);
endmodule

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;
    logic clk = 1'b0, rst_n = 1'b0;
    logic arg_we = 1'b0, cmd_we = 1'b0, cmd_in = 1'b1, dat0_in = 1'b1;
    logic [31:0] arg_wdata = '0;
    logic [9:0]  cmd_wdata = '0;
    logic cmd_out, cmd_oe, st_ready, st_notbusy, st_timeout, st_crcerr, st_overrun;
    logic [127:0] rsp_data;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdcmd_engine dut (.*);

    task automatic check(input bit ok, input string req,
                         input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [119:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [1:0] kind, input bit od, input bit lat,
                           input int delay, input logic [119:0] pay,
                           input bit corrupt, input int busyc, input bit poke);
        logic [47:0] txf, got;
        logic [135:0] rf;
        logic [127:0] exp_rsp;
        bit od_bad = 0;
        int win, n;
        win = lat ? 64 : 5;
        txf = {1'b0, 1'b1, idx, arg, crc7({80'b0, 1'b0, 1'b1, idx, arg}, 40), 1'b1};
        @(negedge clk); arg_we = 1; arg_wdata = arg;
        @(negedge clk); arg_we = 0; cmd_we = 1; cmd_wdata = {lat, od, kind, idx};
        @(negedge clk); cmd_we = 0;
        for (int i = 0; i < 48; i++) begin
            if (i == 0)
                check(!st_timeout && !st_crcerr && !st_overrun, "R10 flags clear on launch",
                      {st_timeout, st_crcerr, st_overrun}, 0);
            if (od) begin
                if (cmd_oe && cmd_out) od_bad = 1;
                got[47 - i] = !cmd_oe;
                got[47 - i] = cmd_oe ? 1'b0 : 1'b1;
            end else begin
                if (!cmd_oe) od_bad = 1;
                got[47 - i] = cmd_out;
            end
            if (poke && i == 10) begin
                cmd_we = 1; cmd_wdata = ~cmd_wdata; arg_we = 1; arg_wdata = ~arg;
            end
            if (poke && i == 11) begin cmd_we = 0; arg_we = 0; end
            @(negedge clk);
        end
        check(got == txf, "R1/R2 command frame", got, txf);
        check(!od_bad, "R3 line drive mode", od_bad, 0);
        if (poke) check(st_overrun, "R9 overrun flag during TX", st_overrun, 1);
        if (kind == 2'd0) begin
            check(st_ready && !cmd_oe, "R4 ready after end bit", {st_ready, cmd_oe}, 2'b10);
            return;
        end
        if (delay >= win) begin
            repeat (win) @(negedge clk);
            check(st_ready && st_timeout, "R5 timeout", {st_ready, st_timeout}, 2'b11);
            return;
        end
        repeat (delay) @(negedge clk);
        check(!st_ready && !st_timeout, "R5 still waiting", {st_ready, st_timeout}, 2'b00);
        if (kind == 2'd2) begin
            n = 136;
            rf = {8'b0011_1111, pay, crc7(pay, 120), 1'b1};
            if (corrupt) rf[60] = ~rf[60];
            exp_rsp = rf[127:0];
        end else begin
            n = 48;
            rf = '0;
            rf[47:0] = {1'b0, 1'b0, idx, pay[31:0],
                        crc7({80'b0, 1'b0, 1'b0, idx, pay[31:0]}, 40), 1'b1};
            if (corrupt) rf[20] = ~rf[20];
            exp_rsp = {96'b0, rf[39:8]};
        end
        for (int b = n - 1; b >= 0; b--) begin
            cmd_in = rf[b];
            @(negedge clk);
        end
        cmd_in = 1;
        if (kind == 2'd3) begin
            dat0_in = 0;
            check(!st_notbusy && !st_ready, "R8 busy after response", {st_notbusy, st_ready}, 0);
            for (int c = 0; c < busyc; c++) begin
                if (c == 0 && busyc >= 2) cmd_we = 1;
                @(negedge clk);
                if (c == 0 && busyc >= 2) begin
                    cmd_we = 0;
                    check(!cmd_oe && !st_notbusy && st_overrun, "R9 write ignored while busy",
                          {cmd_oe, st_notbusy, st_overrun}, 3'b001);
                end
                check(!st_notbusy, "R8 held busy", st_notbusy, 0);
            end
            dat0_in = 1;
            @(negedge clk);
            if (busyc == 0) begin
                check(!st_notbusy, "R8 minimum hold", st_notbusy, 0);
                @(negedge clk);
            end
            check(st_notbusy && st_ready, "R8 busy released", {st_notbusy, st_ready}, 2'b11);
        end else begin
            check(st_ready, "R4 ready after response", st_ready, 1);
        end
        check(st_crcerr == corrupt, "R7 response crc", st_crcerr, corrupt);
        check(rsp_data == exp_rsp, "R6 response data", rsp_data, exp_rsp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(st_ready && st_notbusy && !st_timeout && !st_crcerr && !st_overrun
              && !cmd_oe && rsp_data == 0, "R10 reset state",
              {st_ready, st_notbusy, st_timeout, st_crcerr, st_overrun, cmd_oe}, 6'b110000);
        // directed corners
        run_cmd(6'd2, 32'h0, 2'd2, 1, 0, 2, {4{30'h2AB3_C5D1}}, 0, 0, 0);    // R3 identification, long
        run_cmd(6'd0, 32'hDEAD_BEEF, 2'd0, 0, 0, 0, '0, 0, 0, 0);            // R4 none
        run_cmd(6'd17, 32'h1234_5678, 2'd1, 0, 0, 4, 120'hA5C3_0F11, 0, 0, 1); // R5 last slot, R9 TX
        run_cmd(6'd17, 32'h1, 2'd1, 0, 0, 5, '0, 0, 0, 0);                   // R5 timeout edge
        run_cmd(6'd9, 32'h2, 2'd1, 0, 1, 40, 120'h55, 0, 0, 0);              // R5 long window
        run_cmd(6'd9, 32'h3, 2'd1, 0, 1, 63, 120'h77, 0, 0, 0);              // R5 long last slot
        run_cmd(6'd9, 32'h3, 2'd1, 0, 1, 64, '0, 0, 0, 0);                   // R5 long timeout
        run_cmd(6'd13, 32'h4, 2'd1, 0, 0, 0, 120'hFFFF_FFFF, 1, 0, 0);       // R7 short corrupt
        run_cmd(6'd10, 32'h5, 2'd2, 0, 0, 1, {4{30'h1357_9BDF}}, 1, 0, 0);   // R7 long corrupt
        run_cmd(6'd12, 32'h0, 2'd3, 0, 0, 1, 120'h0900, 0, 3, 0);            // R8/R9 busy
        run_cmd(6'd12, 32'h0, 2'd3, 0, 0, 0, 120'h0900, 0, 0, 0);            // R8 hold minimum
        for (int k = 0; k < 40; k++) begin
            logic [1:0] kd = 2'($urandom_range(0, 3));
            bit lt = bit'($urandom_range(0, 1));
            int dl = lt ? $urandom_range(0, 66) : $urandom_range(0, 6);
            run_cmd(6'($urandom), $urandom, kd, bit'($urandom_range(0, 1)), lt, dl,
                    {$urandom, $urandom, $urandom, 24'($urandom)},
                    ($urandom_range(0, 3) == 0), $urandom_range(0, 4),
                    ($urandom_range(0, 4) == 0));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule